// File: doc/BRIEF.md
# Run-length reset-interval bit decoder

This block recovers a serial bit stream from a single control line. The line is either high, meaning the downstream logic is running, or low, meaning it is held in reset. The sender chooses how long each running interval lasts, and the decoder turns each length into a symbol. A run of about one unit length is a data 0. A run of about two units is a data 1. A run of about three units marks the start of a packet. A run far longer than any symbol means the line is back in ordinary operation, with no programming traffic.

A low stretch counts as a reset only when it lasts at least a programmable hold time. Shorter dips are treated as glitches: they neither end the run nor add to its length. The run length is taken when the next qualified reset arrives. The unit length, the hold time and the normal-mode timeout are inputs, all counted in clock cycles. Data bits are collected MSB first into bytes.

Top module: `runlen_bit_decoder`

## Requirements
- R1: A low stretch counts as a qualified reset only if it lasts at least `hold_len_i` consecutive cycles after synchronization. A shorter dip has no effect and does not end the run. A dip of exactly `hold_len_i` cycles qualifies.
- R2: The run length L is the number of synchronized high cycles since the previous qualified reset. The first qualified reset after `rst_ni` is released decodes nothing.
- R3: If L < 1.5·U, where U is `unit_len_i` and half of U is rounded down, the decoder pulses `bit_vld_o` with `bit_o` = 0.
- R4: If 1.5·U ≤ L < 2.5·U, the decoder pulses `bit_vld_o` with `bit_o` = 1.
- R5: If 2.5·U ≤ L < 3.5·U, the decoder pulses `frame_start_o` with no bit strobe. This clears the partial byte and clears `normal_o`.
- R6: If 3.5·U ≤ L ≤ `normal_len_i`, the run has no effect: no strobe, and the partial byte is kept.
- R7: When the run count passes `normal_len_i`, `normal_o` rises while the line is still high, and the partial byte is discarded. The end of that run decodes nothing. `normal_o` rises 4 cycles after the bench drives the crossing high sample, and it is low one cycle earlier.
- R8: Data bits shift in MSB first. On the 8th bit, `byte_vld_o` pulses in the same cycle as `bit_vld_o`, with the assembled byte on `byte_o`. The bit count then restarts, and `byte_o` holds until the next byte.
- R9: The strobes for a qualified reset appear `hold_len_i` + 3 cycles after the cycle in which the bench drives the line low.
- R10: While `rst_ni` is low, all strobes, `normal_o`, `bit_o` and `byte_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Control line; high = running, low = held in reset |
| unit_len_i | input | CNT_W | Unit run length in cycles |
| hold_len_i | input | CNT_W | Minimum low time for a qualified reset, in cycles (at least 1) |
| normal_len_i | input | CNT_W | Normal-mode timeout in cycles (at least 3.5 units, below counter maximum) |
| bit_vld_o | output | 1 | One-cycle strobe for a decoded data bit |
| bit_o | output | 1 | Decoded data bit |
| frame_start_o | output | 1 | One-cycle strobe for a packet-start marker |
| normal_o | output | 1 | Normal-operation flag |
| byte_vld_o | output | 1 | One-cycle strobe for a completed byte |
| byte_o | output | BYTE_W | Assembled byte, MSB first |

## Verification
The line crosses a two-flop synchronizer. A low stretch then needs `hold_len_i` counted cycles, one registered qualification stage and one registered output stage. So every bit, marker and byte strobe is due exactly `hold_len_i` + 3 cycles after the low is driven. The normal flag is due 4 cycles after the high sample that crosses the timeout. The bench logs each expected strobe together with its due cycle when it drives the stimulus. A monitor at the falling edge then requires the strobe to appear in that exact cycle, with the expected bit and byte. Any strobe nobody expected, or any strobe whose cycle passes without it, counts as a failure. The normal flag is sampled one cycle before and in its due cycle.

// File: rtl/rld_pkg.sv
package rld_pkg;
  typedef enum logic [2:0] {
    RUN_ZERO,
    RUN_ONE,
    RUN_MARK,
    RUN_IGNORE,
    RUN_LONG
  } run_class_e;
endpackage

// File: rtl/rld_sync.sv
module rld_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rld_interval.sv
module rld_interval #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_s_i,
  input  logic [CNT_W-1:0] hold_len_i,
  input  logic [CNT_W-1:0] normal_len_i,
  output logic             end_vld_o,
  output logic [CNT_W-1:0] end_len_o,
  output logic             long_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lo_cnt_q, lo_cnt_n;
  logic [CNT_W-1:0] run_cnt_q, run_cnt_n;
  logic [CNT_W-1:0] end_len_q;
  logic             armed_q, end_vld_q, long_q;
  logic             qual, long_hit;

  always_comb begin
    qual      = !line_s_i && (lo_cnt_q == hold_len_i - 1'b1);
    long_hit  = line_s_i && (run_cnt_q == normal_len_i);
    lo_cnt_n  = lo_cnt_q;
    if (line_s_i)                    lo_cnt_n = '0;
    else if (lo_cnt_q != hold_len_i) lo_cnt_n = lo_cnt_q + 1'b1;
    run_cnt_n = run_cnt_q;
    if (qual)                                run_cnt_n = '0;
    else if (line_s_i && run_cnt_q != CNT_MAX) run_cnt_n = run_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q  <= '0;
      run_cnt_q <= '0;
      end_len_q <= '0;
      armed_q   <= 1'b0;
      end_vld_q <= 1'b0;
      long_q    <= 1'b0;
    end else begin
      lo_cnt_q  <= lo_cnt_n;
      run_cnt_q <= run_cnt_n;
      if (qual) end_len_q <= run_cnt_q;
      if (qual) armed_q   <= 1'b1;
      end_vld_q <= qual && armed_q;
      long_q    <= long_hit;
    end
  end

  assign end_vld_o = end_vld_q;
  assign end_len_o = end_len_q;
  assign long_o    = long_q;

  p_end_after_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_vld_q |-> $past(!line_s_i));
  p_run_frozen_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_s_i && !qual) |=> run_cnt_q == $past(run_cnt_q));
  p_long_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_q |=> !long_q);
endmodule

// File: rtl/rld_classify.sv
module rld_classify
  import rld_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] unit_len_i,
  input  logic [CNT_W-1:0] normal_len_i,
  output run_class_e       cls_o
);
  localparam int WW = CNT_W + 2;

  logic [WW-1:0] u_w, half_w, t01, t12, t23, len_w, norm_w;

  always_comb begin
    u_w    = WW'(unit_len_i);
    half_w = u_w >> 1;
    t01    = u_w + half_w;
    t12    = (u_w << 1) + half_w;
    t23    = (u_w << 1) + u_w + half_w;
    len_w  = WW'(len_i);
    norm_w = WW'(normal_len_i);
    if (len_w > norm_w)  cls_o = RUN_LONG;
    else if (len_w < t01) cls_o = RUN_ZERO;
    else if (len_w < t12) cls_o = RUN_ONE;
    else if (len_w < t23) cls_o = RUN_MARK;
    else                  cls_o = RUN_IGNORE;
  end
endmodule

// File: rtl/rld_assembler.sv
module rld_assembler
  import rld_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_vld_i,
  input  run_class_e        cls_i,
  input  logic              long_i,
  output logic              bit_vld_o,
  output logic              bit_o,
  output logic              frame_start_o,
  output logic              normal_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_n, byte_q, byte_n;
  logic [BC_W-1:0]   bc_q, bc_n;
  logic              norm_q, norm_n, bit_q, bit_n;
  logic              bv_q, bv_n, fs_q, fs_n, byv_q, byv_n;

  always_comb begin
    sh_n   = sh_q;
    bc_n   = bc_q;
    byte_n = byte_q;
    norm_n = norm_q;
    bit_n  = bit_q;
    bv_n   = 1'b0;
    fs_n   = 1'b0;
    byv_n  = 1'b0;
    if (long_i) begin
      sh_n   = '0;
      bc_n   = '0;
      norm_n = 1'b1;
    end
    if (end_vld_i) begin
      unique case (cls_i)
        RUN_ZERO, RUN_ONE: begin
          bv_n  = 1'b1;
          bit_n = (cls_i == RUN_ONE);
          sh_n  = {sh_q[BYTE_W-2:0], bit_n};
          if (bc_q == BC_LAST) begin
            bc_n   = '0;
            byv_n  = 1'b1;
            byte_n = sh_n;
          end else begin
            bc_n = bc_q + 1'b1;
          end
        end
        RUN_MARK: begin
          sh_n   = '0;
          bc_n   = '0;
          fs_n   = 1'b1;
          norm_n = 1'b0;
        end
        RUN_LONG: begin
          sh_n   = '0;
          bc_n   = '0;
          norm_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bc_q   <= '0;
      byte_q <= '0;
      norm_q <= 1'b0;
      bit_q  <= 1'b0;
      bv_q   <= 1'b0;
      fs_q   <= 1'b0;
      byv_q  <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      bc_q   <= bc_n;
      byte_q <= byte_n;
      norm_q <= norm_n;
      bit_q  <= bit_n;
      bv_q   <= bv_n;
      fs_q   <= fs_n;
      byv_q  <= byv_n;
    end
  end

  assign bit_vld_o     = bv_q;
  assign bit_o         = bit_q;
  assign frame_start_o = fs_q;
  assign normal_o      = norm_q;
  assign byte_vld_o    = byv_q;
  assign byte_o        = byte_q;

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bv_q, fs_q}));
  p_mark_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> (bc_q == '0) && !norm_q);
  p_byte_with_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byv_q |-> bv_q && (bc_q == '0));
  p_norm_after_long_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_i |=> norm_q && (bc_q == '0));
endmodule

// File: rtl/runlen_bit_decoder.sv
module runlen_bit_decoder
  import rld_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic [CNT_W-1:0]  unit_len_i,
  input  logic [CNT_W-1:0]  hold_len_i,
  input  logic [CNT_W-1:0]  normal_len_i,
  output logic              bit_vld_o,
  output logic              bit_o,
  output logic              frame_start_o,
  output logic              normal_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic             line_s;
  logic             end_vld, long_pulse;
  logic [CNT_W-1:0] end_len;
  run_class_e       cls;

  rld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  rld_interval #(.CNT_W(CNT_W)) u_interval (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_s_i    (line_s),
    .hold_len_i  (hold_len_i),
    .normal_len_i(normal_len_i),
    .end_vld_o   (end_vld),
    .end_len_o   (end_len),
    .long_o      (long_pulse)
  );

  rld_classify #(.CNT_W(CNT_W)) u_classify (
    .len_i       (end_len),
    .unit_len_i  (unit_len_i),
    .normal_len_i(normal_len_i),
    .cls_o       (cls)
  );

  rld_assembler #(.BYTE_W(BYTE_W)) u_assembler (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .end_vld_i    (end_vld),
    .cls_i        (cls),
    .long_i       (long_pulse),
    .bit_vld_o    (bit_vld_o),
    .bit_o        (bit_o),
    .frame_start_o(frame_start_o),
    .normal_o     (normal_o),
    .byte_vld_o   (byte_vld_o),
    .byte_o       (byte_o)
  );
endmodule

// File: tb/runlen_bit_decoder_tb_top.sv
module runlen_bit_decoder_tb_top;
  localparam int CW   = 16;
  localparam int UNIT = 40;
  localparam int HOLD = 12;
  localparam int NORM = 400;
  localparam int T01  = UNIT + UNIT / 2;
  localparam int T12  = 2 * UNIT + UNIT / 2;
  localparam int T23  = 3 * UNIT + UNIT / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line_i = 1'b1;
  logic bit_vld_o, bit_o, frame_start_o, normal_o, byte_vld_o;
  logic [7:0] byte_o;

  always #2.5 clk = ~clk;

  runlen_bit_decoder #(.CNT_W(CW), .BYTE_W(8), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i),
    .unit_len_i(CW'(UNIT)), .hold_len_i(CW'(HOLD)), .normal_len_i(CW'(NORM)),
    .bit_vld_o(bit_vld_o), .bit_o(bit_o), .frame_start_o(frame_start_o),
    .normal_o(normal_o), .byte_vld_o(byte_vld_o), .byte_o(byte_o)
  );

  typedef struct {
    int unsigned due;
    bit fs, bv, b, byv;
    logic [7:0] by;
    string tag;
  } ev_t;

  ev_t q[$];
  int unsigned cyc = 0;
  int n_chk = 0, n_bad = 0, strobes = 0;
  bit done = 1'b0;
  int unsigned hi_acc = 0, norm_due = 0;
  bit armed = 1'b0, m_norm = 1'b0;
  logic [7:0] sh = '0;
  int bcnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int cls_of(input int unsigned l);
    if (l > NORM) return 4;
    if (l < T01)  return 0;
    if (l < T12)  return 1;
    if (l < T23)  return 2;
    return 3;
  endfunction

  task automatic push_event(input int unsigned c);
    ev_t e;
    int k;
    e.due = c + HOLD + 3;
    e.fs = 0; e.bv = 0; e.b = 0; e.byv = 0; e.by = '0;
    k = cls_of(hi_acc);
    case (k)
      0, 1: begin
        e.bv = 1; e.b = (k == 1);
        sh = {sh[6:0], e.b};
        bcnt++;
        e.tag = (k == 1) ? "R4,R9" : "R3,R9";
        if (bcnt == 8) begin
          e.byv = 1; e.by = sh; bcnt = 0; e.tag = {e.tag, ",R8"};
        end
        q.push_back(e);
      end
      2: begin
        e.fs = 1; e.tag = "R5,R9"; sh = '0; bcnt = 0; m_norm = 0;
        q.push_back(e);
      end
      4: begin sh = '0; bcnt = 0; m_norm = 1; end
      default: ;
    endcase
  endtask

  task automatic run_hi(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      line_i = 1'b1;
      hi_acc++;
      if (hi_acc == NORM + 1) begin
        if (!m_norm) norm_due = cyc + 4;
        m_norm = 1; sh = '0; bcnt = 0;
      end
    end
  endtask

  task automatic go_low(input int m);
    for (int j = 0; j < m; j++) begin
      @(negedge clk);
      line_i = 1'b0;
      if (j == 0 && m >= HOLD) begin
        if (armed) push_event(cyc);
        armed = 1; hi_acc = 0;
      end
    end
  endtask

  task automatic send_bit(input bit b);
    run_hi(b ? 80 : 40);
    go_low(HOLD + 2);
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (bit_vld_o || frame_start_o || byte_vld_o) begin
        strobes++;
        if (q.size() == 0) begin
          chk(0, "R2/R6", "unexpected strobe", {frame_start_o, bit_vld_o}, 0);
        end else begin
          ev_t e;
          e = q.pop_front();
          chk(cyc == e.due, e.tag, "strobe cycle", cyc, e.due);
          chk({frame_start_o, bit_vld_o, bit_vld_o & bit_o, byte_vld_o} ==
              {e.fs, e.bv, e.b, e.byv}, e.tag, "strobe kind",
              {frame_start_o, bit_vld_o, bit_vld_o & bit_o, byte_vld_o},
              {e.fs, e.bv, e.b, e.byv});
          if (e.byv) chk(byte_o == e.by, e.tag, "byte value", byte_o, e.by);
          if (e.fs) chk(normal_o == 0, "R5", "normal after marker", normal_o, 0);
        end
      end else if (q.size() > 0 && q[0].due < cyc) begin
        ev_t e;
        e = q.pop_front();
        chk(0, e.tag, "missing strobe", cyc, e.due);
      end
      if (norm_due != 0) begin
        if (cyc == norm_due - 1) chk(normal_o == 0, "R7", "normal early", normal_o, 0);
        if (cyc == norm_due) begin
          chk(normal_o == 1, "R7", "normal rise", normal_o, 1);
          norm_due = 0;
        end
      end
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    done = 1'b1;
    report();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    chk({bit_vld_o, frame_start_o, normal_o, byte_vld_o, bit_o, byte_o} == '0,
        "R10", "in reset", {bit_vld_o, frame_start_o, normal_o, byte_vld_o, byte_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({bit_vld_o, frame_start_o, normal_o, byte_vld_o, byte_o} == '0,
        "R10", "after release", {bit_vld_o, frame_start_o, normal_o, byte_o}, 0);

    // R2: first qualified reset decodes nothing
    run_hi(50); go_low(HOLD + 6);
    chk(strobes == 0, "R2", "first reset silent", strobes, 0);

    // marker, then bit-length boundaries
    run_hi(120); go_low(HOLD + 2);
    run_hi(T01 - 1); go_low(HOLD);
    run_hi(T01);     go_low(HOLD + 1);
    run_hi(T12 - 1); go_low(HOLD + 3);
    // R1: dip one cycle short of the hold is ignored; run lengths add up
    run_hi(20); go_low(HOLD - 1); run_hi(30); go_low(HOLD + 1);
    run_hi(T12);     go_low(HOLD + 2);
    run_hi(T23 - 1); go_low(HOLD + 2);
    // R6: ignored lengths at both edges of the window
    run_hi(T23);     go_low(HOLD + 2);
    run_hi(NORM);    go_low(HOLD + 2);

    // R8: byte A5 with an ignored run in the middle (R6 keeps partial)
    run_hi(110); go_low(HOLD + 2);
    send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    run_hi(200); go_low(HOLD + 2);
    send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    repeat (HOLD + 6) @(negedge clk);
    chk(byte_o == 8'hA5, "R8", "byte holds", byte_o, 8'hA5);

    // R7: long run sets normal and discards the partial byte
    run_hi(110); go_low(HOLD + 2);
    send_bit(1); send_bit(1); send_bit(1);
    run_hi(NORM + 60); go_low(HOLD + 2);
    send_bit(0); send_bit(0); send_bit(1); send_bit(1);
    send_bit(0); send_bit(1); send_bit(0); send_bit(0);
    repeat (HOLD + 6) @(negedge clk);
    chk(normal_o == 1, "R7", "normal held", normal_o, 1);
    chk(byte_o == 8'h34, "R7", "partial discarded", byte_o, 8'h34);
    run_hi(105); go_low(HOLD + 2);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int k, n;
      k = $urandom_range(0, 9);
      if (k < 4)       n = $urandom_range(1, T01 - 1);
      else if (k < 8)  n = $urandom_range(T01, T12 - 1);
      else if (k == 8) n = $urandom_range(T12, T23 - 1);
      else             n = $urandom_range(T23, NORM);
      if (n > 2 && $urandom_range(0, 4) == 0) begin
        int a;
        a = $urandom_range(1, n - 1);
        run_hi(a); go_low($urandom_range(1, HOLD - 1)); run_hi(n - a);
      end else begin
        run_hi(n);
      end
      go_low(HOLD + $urandom_range(0, 8));
    end

    run_hi(10);
    repeat (HOLD + 10) @(negedge clk);
    chk(q.size() == 0, "R9", "all strobes seen", q.size(), 0);
    done = 1'b1;
    report();
  end
endmodule